// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits beside the byte stream of an Ethernet receiver and decides, for every incoming frame, whether the frame is kept. It watches the first six bytes of the frame (the destination address) as they arrive and, one cycle after the sixth one, presents a registered keep/drop verdict that stays put until the next frame begins. The receiver's remaining logic uses that verdict to commit or discard the frame while the rest of the header is still streaming in.

Four rules feed the verdict. An exact comparison against the station's own address. A broadcast rule with its own enable. A promiscuous override that keeps everything. A 64-bin hash table indexed by six bits of a CRC-32 taken over the destination bytes. The table always governs group (multicast) addresses. It can optionally also admit individual addresses that miss the exact comparison. The CRC runs one byte per accepted cycle, so gaps in the byte stream are harmless.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, `dec_valid` and `dec_accept` are both 0.
- R2: A frame starts on a cycle with `rx_vld` and `rx_sof` both high; that byte is destination byte 0. Only cycles with `rx_vld` high count as bytes. `dec_valid` is 0 while the sixth byte is presented and rises in the cycle after the edge that takes the sixth byte, whatever idle cycles lie between bytes.
- R3: Once `dec_valid` is high, the verdict holds through further payload bytes and configuration changes. Both outputs return to 0 at the edge that takes the next frame's first byte.
- R4: The station address is byte 0 = `sta_addr_hi[15:8]`, byte 1 = `sta_addr_hi[7:0]`, byte 2 = `sta_addr_lo[31:24]`, down to byte 5 = `sta_addr_lo[7:0]`, where byte 0 is received first. A destination equal to it is accepted.
- R5: With `cfg_uni_hash` low, a destination is rejected if it is individual (byte 0 bit 0 = 0) and differs from the station address. The hash table is not consulted in this case.
- R6: The all-ones destination is accepted when `cfg_bcast_ok` is 1. It is rejected when `cfg_bcast_ok` is 0, whatever the hash table holds.
- R7: A group destination (byte 0 bit 0 = 1, not all ones) is accepted exactly when the table bit at index k is set. The CRC register starts at all ones. Each byte is shifted in LSB first with the reflected polynomial 0xEDB88320: for each bit, feedback = crc[0] XOR data bit, crc = crc >> 1, and the polynomial is XORed in when the feedback is 1. There is no final inversion. k is bits 31:26 of the register after the six bytes. k[5] = 1 selects `hash_tbl_hi`, k[5] = 0 selects `hash_tbl_lo`, and k[4:0] is the bit position within that register.
- R8: With both hash registers all ones, every group destination is accepted.
- R9: With `cfg_uni_hash` high, an individual destination that differs from the station address is accepted exactly when its hash bit is set.
- R10: With `cfg_promisc` high, every destination is accepted, including broadcast when `cfg_bcast_ok` is 0.
- R11: A new frame start while address bytes are still arriving abandons the partial address. The count restarts, and the verdict concerns only the new frame's six bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_vld | input | 1 | A received byte is present this cycle |
| rx_sof | input | 1 | With `rx_vld`, marks the first byte of a frame |
| rx_byte | input | 8 | Received byte |
| sta_addr_lo | input | 32 | Station address bytes 2..5 (byte 2 in the top bits) |
| sta_addr_hi | input | 16 | Station address bytes 0 and 1 (byte 0 in the top bits) |
| hash_tbl_lo | input | 32 | Hash bins 0..31 |
| hash_tbl_hi | input | 32 | Hash bins 32..63 |
| cfg_promisc | input | 1 | Keep every frame |
| cfg_bcast_ok | input | 1 | Keep broadcast frames |
| cfg_uni_hash | input | 1 | Let individual addresses also pass on their hash bit |
| dec_valid | output | 1 | Verdict available for the current frame |
| dec_accept | output | 1 | Verdict: 1 keep, 0 drop |

## Verification
The hardest case to reach from the ports is a single hash bin taking effect: a group address must land on one specific bin, in one particular half of the table. The bench computes the CRC index itself for several group addresses and programs only that bin. It then programs every bin except that one. This exposes a wrong bit order, a wrong polynomial or swapped table halves. Frames with idle gaps, frames that are abandoned midway and then restart, and configuration changes after the verdict are driven as directed sequences.

// File: rtl/rxf_pkg.sv
// Shared constants and the byte-wide CRC step used by the address filter.
// Assumes the reflected CRC-32 form with bytes entering LSB first.
package rxf_pkg;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;
    localparam logic [31:0] CRC_SEED      = 32'hFFFF_FFFF;

    // Advance the CRC register over one byte, least significant bit first.
    function automatic logic [31:0] crc_step_byte(input logic [31:0] crc_in,
                                                  input logic [7:0]  data);
        logic [31:0] c;
        logic        fb;
        c = crc_in;
        for (int i = 0; i < 8; i++) begin
            fb = c[0] ^ data[i];
            c  = c >> 1;
            if (fb) c = c ^ CRC_POLY_REFL;
        end
        return c;
    endfunction

endpackage

// File: rtl/rxf_byte_track.sv
// Counts the destination-address bytes of the current frame.
// Assumes a frame opens with rx_vld & rx_sof; until then, stray bytes are ignored.
module rxf_byte_track #(
    parameter int ADDR_BYTES = 6,
    localparam int IW = $clog2(ADDR_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_vld,
    input  logic          rx_sof,
    output logic          frame_start,
    output logic          take,
    output logic          last,
    output logic [IW-1:0] idx
);

    localparam logic [IW-1:0] IDLE_CNT = IW'(ADDR_BYTES);
    localparam logic [IW-1:0] LAST_IDX = IW'(ADDR_BYTES - 1);

    logic [IW-1:0] cnt_q;

    // Classify the current byte: frame start, address byte, last address byte.
    always_comb begin
        frame_start = rx_vld & rx_sof;
        take        = rx_vld & (rx_sof | (cnt_q < IDLE_CNT));
        idx         = rx_sof ? '0 : cnt_q;
        last        = take & (idx == LAST_IDX);
    end

    // Count taken address bytes; parks at IDLE_CNT until the next frame start.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= IDLE_CNT;
        else if (frame_start) cnt_q <= IW'(1);
        else if (take)        cnt_q <= cnt_q + IW'(1);
    end

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= IDLE_CNT);
    p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (cnt_q == IW'(1)));

endmodule

// File: rtl/rxf_crc_hash.sv
// Runs the CRC over the address bytes and looks up the hash bin of the
// running result, combinationally, so the bin is known in the last-byte cycle.
// Assumes the table is the two hash registers concatenated {hi, lo}.
module rxf_crc_hash #(
    parameter int HASH_BITS = 6,
    localparam int TBL_SZ = 1 << HASH_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              first,
    input  logic              take,
    input  logic [7:0]        rx_byte,
    input  logic [TBL_SZ-1:0] hash_tbl,
    output logic              hash_hit
);

    import rxf_pkg::*;

    logic [31:0]          crc_q;
    logic [31:0]          crc_next;
    logic [HASH_BITS-1:0] bin;

    // Next CRC value: restart from the seed on the first byte of a frame.
    always_comb begin
        crc_next = crc_step_byte(first ? CRC_SEED : crc_q, rx_byte);
        bin      = crc_next[31 -: HASH_BITS];
        hash_hit = hash_tbl[bin];
    end

    // Hold the running CRC between address bytes.
    always_ff @(posedge clk) begin
        if (!rst_n)    crc_q <= CRC_SEED;
        else if (take) crc_q <= crc_next;
    end

    p_crc_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(crc_q));

endmodule

// File: rtl/rxf_addr_cmp.sv
// Tracks, byte by byte, whether the destination still equals the station
// address, whether it is still all ones, and whether it is a group address.
// Outputs are the flag values including the current byte.
module rxf_addr_cmp #(
    parameter int ADDR_BYTES = 6,
    localparam int IW = $clog2(ADDR_BYTES + 1),
    localparam int AW = 8 * ADDR_BYTES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          first,
    input  logic          take,
    input  logic [IW-1:0] idx,
    input  logic [7:0]    rx_byte,
    input  logic [AW-1:0] sta_addr,
    output logic          eq_next,
    output logic          ones_next,
    output logic          grp_next
);

    logic [ADDR_BYTES-1:0] byte_eq;
    logic                  eq_q, ones_q, grp_q;

    // One comparator per station byte; byte 0 occupies the top bits.
    for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_cmp
        assign byte_eq[k] = (rx_byte == sta_addr[AW-1-8*k -: 8]);
    end

    // Fold the current byte into the running flags.
    always_comb begin
        eq_next   = (first | eq_q) & byte_eq[idx];
        ones_next = (first | ones_q) & (rx_byte == 8'hFF);
        grp_next  = first ? rx_byte[0] : grp_q;
    end

    // Register the running flags on each address byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eq_q   <= 1'b0;
            ones_q <= 1'b0;
            grp_q  <= 1'b0;
        end else if (take) begin
            eq_q   <= eq_next;
            ones_q <= ones_next;
            grp_q  <= grp_next;
        end
    end

    p_flags_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> ($stable(eq_q) && $stable(ones_q) && $stable(grp_q)));

endmodule

// File: rtl/rx_addr_filter.sv
// Receive destination address filter. Issues a registered keep/drop verdict
// one cycle after the sixth destination byte and holds it until the next frame.
// Assumes a byte-wide receive stream with a start-of-frame marker.
module rx_addr_filter #(
    parameter int ADDR_BYTES = 6,
    parameter int HASH_BITS  = 6,
    localparam int IW     = $clog2(ADDR_BYTES + 1),
    localparam int TBL_SZ = 1 << HASH_BITS,
    localparam int HALF   = TBL_SZ / 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_vld,
    input  logic            rx_sof,
    input  logic [7:0]      rx_byte,
    input  logic [31:0]     sta_addr_lo,
    input  logic [15:0]     sta_addr_hi,
    input  logic [HALF-1:0] hash_tbl_lo,
    input  logic [HALF-1:0] hash_tbl_hi,
    input  logic            cfg_promisc,
    input  logic            cfg_bcast_ok,
    input  logic            cfg_uni_hash,
    output logic            dec_valid,
    output logic            dec_accept
);

    logic          frame_start, take, last;
    logic [IW-1:0] idx;
    logic          hash_hit, eq_next, ones_next, grp_next;
    logic          verdict;

    rxf_byte_track #(.ADDR_BYTES(ADDR_BYTES)) u_track (
        .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_sof(rx_sof),
        .frame_start(frame_start), .take(take), .last(last), .idx(idx)
    );

    rxf_crc_hash #(.HASH_BITS(HASH_BITS)) u_crc (
        .clk(clk), .rst_n(rst_n), .first(frame_start), .take(take),
        .rx_byte(rx_byte), .hash_tbl({hash_tbl_hi, hash_tbl_lo}),
        .hash_hit(hash_hit)
    );

    rxf_addr_cmp #(.ADDR_BYTES(ADDR_BYTES)) u_cmp (
        .clk(clk), .rst_n(rst_n), .first(frame_start), .take(take),
        .idx(idx), .rx_byte(rx_byte),
        .sta_addr({sta_addr_hi, sta_addr_lo}),
        .eq_next(eq_next), .ones_next(ones_next), .grp_next(grp_next)
    );

    // Combine the address class with the mode bits into a keep/drop verdict.
    always_comb begin
        if (cfg_promisc)    verdict = 1'b1;
        else if (ones_next) verdict = cfg_bcast_ok;
        else if (grp_next)  verdict = hash_hit;
        else                verdict = eq_next | (cfg_uni_hash & hash_hit);
    end

    // Capture the verdict on the last address byte; clear it at a frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
        end else if (last) begin
            dec_valid  <= 1'b1;
            dec_accept <= verdict;
        end else if (frame_start) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
        end
    end

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !frame_start) |=> (dec_valid && $stable(dec_accept)));
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !last) |=> (!dec_valid && !dec_accept));
    p_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dec_valid) |-> $past(rx_vld));
    p_promisc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (last && cfg_promisc) |=> dec_accept);
    p_bcast_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (last && ones_next && !cfg_promisc && !cfg_bcast_ok) |=> !dec_accept);
    p_accept_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        dec_accept |-> dec_valid);

endmodule

// File: tb/test_rx_addr_filter.sv
module test_rx_addr_filter;

    localparam logic [47:0] STA = 48'h02_11_22_33_44_55;
    localparam logic [47:0] BC  = 48'hFF_FF_FF_FF_FF_FF;
    localparam logic [63:0] ONES = '1;

    typedef struct packed {
        logic [47:0] da;
        logic [2:0]  mode;   // [2] promisc, [1] bcast_ok, [0] uni_hash
        logic [63:0] hash;   // {hi, lo}
        logic        exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{STA,                  3'b000, 64'h0, 1'b1, 4'd4},   // R4 exact match
        '{48'h02_11_22_33_44_56,3'b000, 64'h0, 1'b0, 4'd5},   // R5 mismatch
        '{48'h02_11_22_33_44_56,3'b000, ONES,  1'b0, 4'd5},   // R5 table ignored
        '{BC,                   3'b010, 64'h0, 1'b1, 4'd6},   // R6 broadcast on
        '{BC,                   3'b000, ONES,  1'b0, 4'd6},   // R6 broadcast off
        '{48'h01_00_5E_00_00_01,3'b000, ONES,  1'b1, 4'd8},   // R8 all bins
        '{48'h01_00_5E_00_00_01,3'b000, 64'h0, 1'b0, 4'd7},   // R7 empty table
        '{48'h03_AA_BB_CC_DD_EE,3'b000, ONES,  1'b1, 4'd8},   // R8
        '{48'h02_11_22_33_44_56,3'b001, ONES,  1'b1, 4'd9},   // R9 hash admits
        '{48'h02_11_22_33_44_56,3'b001, 64'h0, 1'b0, 4'd9},   // R9 hash rejects
        '{48'h02_99_88_77_66_55,3'b100, 64'h0, 1'b1, 4'd10},  // R10 promisc
        '{BC,                   3'b100, 64'h0, 1'b1, 4'd10},  // R10 over bcast off
        '{STA,                  3'b001, 64'h0, 1'b1, 4'd4}    // R4 with hash mode
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_vld = 1'b0, rx_sof = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic [31:0] hash_tbl_lo = '0, hash_tbl_hi = '0;
    logic        cfg_promisc = 1'b0, cfg_bcast_ok = 1'b0, cfg_uni_hash = 1'b0;
    logic        dec_valid, dec_accept;
    int          n_chk = 0, n_fail = 0, cycles = 0;

    always #4 clk = ~clk;

    rx_addr_filter i_rx_addr_filter (
        .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_sof(rx_sof),
        .rx_byte(rx_byte), .sta_addr_lo(STA[31:0]), .sta_addr_hi(STA[47:32]),
        .hash_tbl_lo(hash_tbl_lo), .hash_tbl_hi(hash_tbl_hi),
        .cfg_promisc(cfg_promisc), .cfg_bcast_ok(cfg_bcast_ok),
        .cfg_uni_hash(cfg_uni_hash), .dec_valid(dec_valid), .dec_accept(dec_accept)
    );

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            n_chk  = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Reference index from R7: reflected CRC, LSB first, seed all ones.
    function automatic logic [5:0] ref_bin(input logic [47:0] da);
        logic [31:0] c = '1;
        logic [7:0]  b;
        logic        fb;
        for (int k = 0; k < 6; k++) begin
            b = da[47-8*k -: 8];
            for (int i = 0; i < 8; i++) begin
                fb = c[0] ^ b[i];
                c  = c >> 1;
                if (fb) c = c ^ 32'hEDB88320;
            end
        end
        return c[31:26];
    endfunction

    task automatic set_cfg(input logic [2:0] mode, input logic [63:0] hash);
        @(negedge clk);
        {cfg_promisc, cfg_bcast_ok, cfg_uni_hash} = mode;
        {hash_tbl_hi, hash_tbl_lo} = hash;
    endtask

    // Send a six-byte destination; optional idle gap after each byte.
    // Leaves the stream idle and returns at the negedge after the sixth byte.
    task automatic send_da(input logic [47:0] da, input int gap, input string tag);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (k == 5) check(tag, dec_valid, 1'b0);
            rx_vld = 1'b1; rx_sof = (k == 0); rx_byte = da[47-8*k -: 8];
            for (int g = 0; g < gap && k < 5; g++) begin
                @(negedge clk);
                rx_vld = 1'b0; rx_sof = 1'b0;
            end
        end
        @(negedge clk);
        rx_vld = 1'b0; rx_sof = 1'b0;
    endtask

    initial begin
        logic [5:0]  bin;
        logic [47:0] grp [4] = '{48'h01_00_5E_00_00_01, 48'h33_33_00_00_00_01,
                                 48'h01_80_C2_00_00_00, 48'h0B_12_34_56_78_9A};
        repeat (3) @(negedge clk);
        check("R1", dec_valid, 1'b0);
        check("R1", dec_accept, 1'b0);
        rst_n = 1'b1;

        // Table walk.
        for (int v = 0; v < NV; v++) begin
            set_cfg(VECS[v].mode, VECS[v].hash);
            send_da(VECS[v].da, 0, $sformatf("R2 vector %0d", v));
            check($sformatf("R2 vector %0d valid", v), dec_valid, 1'b1);
            check($sformatf("R%0d vector %0d", VECS[v].req, v), dec_accept, VECS[v].exp);
        end

        // R7: a single bin, then every bin but that one.
        for (int a = 0; a < 4; a++) begin
            bin = ref_bin(grp[a]);
            set_cfg(3'b000, 64'h1 << bin);
            send_da(grp[a], 0, "R7 single bin");
            check("R7 single bin", dec_accept, 1'b1);
            set_cfg(3'b000, ~(64'h1 << bin));
            send_da(grp[a], 0, "R7 all but bin");
            check("R7 all but bin", dec_accept, 1'b0);
            // R9: same bin admits an individual address in hash mode.
            bin = ref_bin({grp[a][47:41], 1'b0, grp[a][39:0]});
            set_cfg(3'b001, 64'h1 << bin);
            send_da({grp[a][47:41], 1'b0, grp[a][39:0]}, 0, "R9 single bin");
            check("R9 single bin", dec_accept, 1'b1);
        end

        // R2: idle gaps between bytes.
        set_cfg(3'b000, 64'h0);
        send_da(STA, 3, "R2 gaps");
        check("R2 gaps valid", dec_valid, 1'b1);
        check("R4 gaps accept", dec_accept, 1'b1);

        // R3: payload bytes and a config change leave the verdict alone.
        for (int p = 0; p < 4; p++) begin
            @(negedge clk);
            rx_vld = 1'b1; rx_sof = 1'b0; rx_byte = 8'hFF;
        end
        @(negedge clk);
        rx_vld = 1'b0; cfg_promisc = 1'b0; cfg_uni_hash = 1'b1;
        @(negedge clk);
        check("R3 hold valid", dec_valid, 1'b1);
        check("R3 hold accept", dec_accept, 1'b1);
        // R3: next frame start clears the verdict.
        rx_vld = 1'b1; rx_sof = 1'b1; rx_byte = 8'h02;
        @(negedge clk);
        rx_vld = 1'b0; rx_sof = 1'b0;
        check("R3 clear valid", dec_valid, 1'b0);
        check("R3 clear accept", dec_accept, 1'b0);

        // R11: abandon a partial address of another station, then restart.
        set_cfg(3'b000, 64'h0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            rx_vld = 1'b1; rx_sof = (k == 0); rx_byte = 8'h77;
        end
        send_da(STA, 0, "R11 restart timing");
        check("R11 restart valid", dec_valid, 1'b1);
        check("R11 restart accept", dec_accept, 1'b1);
        // R11: abandon a station prefix, restart with a foreign address.
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            rx_vld = 1'b1; rx_sof = (k == 0); rx_byte = STA[47-8*k -: 8];
        end
        send_da(48'h02_11_22_33_44_99, 0, "R11 restart timing");
        check("R11 foreign reject", dec_accept, 1'b0);

        // R1: reset in mid-verdict clears outputs.
        set_cfg(3'b100, 64'h0);
        send_da(STA, 0, "R2 pre-reset");
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset valid", dec_valid, 1'b0);
        check("R1 reset accept", dec_accept, 1'b0);
        rst_n = 1'b1;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule